// File: doc/BRIEF.md
# Sub-Second Phase Shift Timebase

This block is the seconds timebase of a real-time clock. A sub-second counter counts down by one on every prescaler tick. When it steps past zero it reloads from a programmable divider value and the seconds counter advances. A write-only shift control word adjusts the phase of this timebase without stopping it. The value in its fraction field is added into the down-counting sub-second counter, which delays the clock by fraction/(divider+1) seconds. If the add-one-second flag is set in the same word, the seconds counter also steps forward in the same update, so the net effect is an advance of 1 − fraction/(divider+1) seconds.

An accepted shift word raises a pending flag. The adjustment is applied on the next prescaler tick, and any further shift word is dropped until that happens. Software-visible shadow copies of the seconds and sub-second values are refreshed on every ordinary tick. An accepted shift word clears a synchronised flag, and the flag is set again one tick after the shift is applied, when the shadows first hold the shifted time. The divider value is expected to change only while reset is held.

Top module: `rtc_shift_timebase`

## Requirements
- R1: While reset is high, at the next clock edge the sub-second counter loads the divider value, and the seconds counter, both shadows, the pending flag and the synchronised flag all go to zero.
- R2: On a tick with no shift applied, the sub-second counter decrements by one. From zero it reloads with the divider value and the seconds counter increments (modulo 2^SEC_W). Without a tick, neither counter changes.
- R3: In the shift word, bits 14:0 are the fraction and bit 31 is the add-one-second flag, and bits 30:15 are ignored. A write made while nothing is pending is accepted, and the pending flag reads 1 after that clock edge.
- R4: A write made while the pending flag is 1 is ignored completely. The latched fraction and flag are kept, and the later adjustment uses them.
- R5: On the first tick with the pending flag set, the sub-second result is the ordinary decremented value plus the latched fraction, and the pending flag is 0 after that same edge.
- R6: If that sum exceeds the divider value, the sub-second counter takes the sum minus (divider+1), and the seconds counter is decremented by one in the same update.
- R7: A latched add-one-second flag increments the seconds counter in the same update in which the fraction is applied, together with any reload carry and wrap borrow.
- R8: A fraction larger than the divider value is treated as equal to the divider value.
- R9: An accepted write clears the synchronised flag after that edge. On the apply tick the shadows are not updated and the flag stays 0. On the next tick the shadows take the shifted values and the flag becomes 1.
- R10: On any tick that does not apply a shift, the shadows copy the seconds and sub-second values held before that tick and the synchronised flag is set, unless a write is accepted in the same cycle, in which case the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shift word write strobe |
| wr_data | input | 32 | Shift word: fraction in 14:0, add-one-second in 31 |
| tick | input | 1 | Synchronous prescaler tick |
| prediv_s | input | 15 | Sub-second divider reload value |
| ss_cnt | output | 15 | Live sub-second counter |
| sec_cnt | output | SEC_W | Live seconds counter |
| shadow_ss | output | 15 | Shadow copy of the sub-second counter |
| shadow_sec | output | SEC_W | Shadow copy of the seconds counter |
| shift_pend | output | 1 | Shift accepted and not yet applied |
| shadow_sync | output | 1 | Shadows hold current (shifted) time |

## Verification
The bench steers the counter so that an applied fraction lands just below, exactly on and above the divider, and so that an apply tick also carries a reload. A design that folded the sum wrongly would leave the counter above the divider, and one that lost the borrow or the carry would be out by one second. It writes a second shift word while one is pending and checks that the first word's values are the ones applied, which catches a design whose latch is overwritten. It also writes in the same cycle as a tick, checking that the clear of the synchronised flag wins and that the adjustment waits for the following tick. Oversized fractions and a divider of zero check the clamp, which an unclamped design would break by leaving the counter out of range.

// File: rtl/rtc_shift_pkg.sv
package rtc_shift_pkg;

    // Sub-second counter and fraction field width (fixed by the word layout)
    localparam int SS_W      = 15;
    localparam int WORD_W    = 32;
    localparam int ADD1_POS  = 31;

    typedef struct packed {
        logic            add1;
        logic [SS_W-1:0] frac;
    } shift_req_t;

    typedef struct packed {
        logic [SS_W-1:0] ss;
        logic            carry;
    } dec_res_t;

    function automatic shift_req_t decode_word(input logic [WORD_W-1:0] w);
        shift_req_t r;
        r.add1 = w[ADD1_POS];
        r.frac = w[SS_W-1:0];
        return r;
    endfunction

    function automatic logic [SS_W-1:0] clamp_frac(input logic [SS_W-1:0] f,
                                                   input logic [SS_W-1:0] lim);
        return (f > lim) ? lim : f;
    endfunction

    function automatic dec_res_t step_down(input logic [SS_W-1:0] cur,
                                           input logic [SS_W-1:0] lim);
        dec_res_t d;
        if (cur == '0) begin
            d.ss    = lim;
            d.carry = 1'b1;
        end else begin
            d.ss    = cur - SS_W'(1);
            d.carry = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/rtc_shift_port.sv
module rtc_shift_port
    import rtc_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tick,
    output logic              pend,
    output shift_req_t        req,
    output logic              accept,
    output logic              apply
);

    assign accept = wr_en & ~pend;
    assign apply  = tick & pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            req  <= '0;
        end else begin
            if (accept) begin
                pend <= 1'b1;
                req  <= decode_word(wr_data);
            end else if (apply) begin
                pend <= 1'b0;
            end
        end
    end

    AST_WRITE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pend) |=> pend); // R3
    AST_PEND_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pend && !tick) |=> (pend && $stable(req))); // R4
    AST_PEND_CLEARS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (pend && tick) |=> !pend); // R5

endmodule

// File: rtl/rtc_subsec_core.sv
module rtc_subsec_core
    import rtc_shift_pkg::*;
#(
    parameter int SEC_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             apply,
    input  shift_req_t       req,
    input  logic [SS_W-1:0]  prediv_s,
    output logic [SS_W-1:0]  ss_q,
    output logic [SEC_W-1:0] sec_q
);

    localparam int SUM_W = SS_W + 1;

    dec_res_t         dec;
    logic [SS_W-1:0]  frac_eff;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] span;
    logic             wrap;
    logic [SS_W-1:0]  ss_n;
    logic [SEC_W-1:0] sec_n;

    always_comb begin
        dec      = step_down(ss_q, prediv_s);
        frac_eff = clamp_frac(req.frac, prediv_s);
        sum      = {1'b0, dec.ss} + {1'b0, frac_eff};
        span     = {1'b0, prediv_s} + SUM_W'(1);
        wrap     = apply && (sum > {1'b0, prediv_s});
        sec_n    = sec_q + SEC_W'(dec.carry);
        if (apply) begin
            ss_n  = wrap ? SS_W'(sum - span) : sum[SS_W-1:0];
            sec_n = sec_n + SEC_W'(req.add1) - SEC_W'(wrap);
        end else begin
            ss_n  = dec.ss;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_q  <= prediv_s;
            sec_q <= '0;
        end else if (tick) begin
            ss_q  <= ss_n;
            sec_q <= sec_n;
        end
    end

    AST_SS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ss_q <= prediv_s); // R6
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(ss_q) && $stable(sec_q))); // R2

endmodule

// File: rtl/rtc_shadow_unit.sv
module rtc_shadow_unit
    import rtc_shift_pkg::*;
#(
    parameter int SEC_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             apply,
    input  logic             accept,
    input  logic [SS_W-1:0]  ss_live,
    input  logic [SEC_W-1:0] sec_live,
    output logic [SS_W-1:0]  sh_ss,
    output logic [SEC_W-1:0] sh_sec,
    output logic             sync
);

    logic refresh;
    assign refresh = tick & ~apply;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_ss  <= '0;
            sh_sec <= '0;
            sync   <= 1'b0;
        end else begin
            if (refresh) begin
                sh_ss  <= ss_live;
                sh_sec <= sec_live;
            end
            if (accept)       sync <= 1'b0;
            else if (refresh) sync <= 1'b1;
        end
    end

    AST_ACCEPT_CLEARS_SYNC: assert property (@(posedge clk) disable iff (rst)
        accept |=> !sync); // R9
    AST_APPLY_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (rst)
        apply |=> ($stable(sh_ss) && $stable(sh_sec) && !sync)); // R9

endmodule

// File: rtl/rtc_shift_timebase.sv
module rtc_shift_timebase
    import rtc_shift_pkg::*;
#(
    parameter int SEC_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             tick,
    input  logic [14:0]      prediv_s,
    output logic [14:0]      ss_cnt,
    output logic [SEC_W-1:0] sec_cnt,
    output logic [14:0]      shadow_ss,
    output logic [SEC_W-1:0] shadow_sec,
    output logic             shift_pend,
    output logic             shadow_sync
);

    shift_req_t req;
    logic       accept;
    logic       apply;

    rtc_shift_port u_port (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tick    (tick),
        .pend    (shift_pend),
        .req     (req),
        .accept  (accept),
        .apply   (apply)
    );

    rtc_subsec_core #(.SEC_W(SEC_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .apply    (apply),
        .req      (req),
        .prediv_s (prediv_s),
        .ss_q     (ss_cnt),
        .sec_q    (sec_cnt)
    );

    rtc_shadow_unit #(.SEC_W(SEC_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .apply    (apply),
        .accept   (accept),
        .ss_live  (ss_cnt),
        .sec_live (sec_cnt),
        .sh_ss    (shadow_ss),
        .sh_sec   (shadow_sec),
        .sync     (shadow_sync)
    );

    AST_REFRESH_SETS_SYNC: assert property (@(posedge clk) disable iff (rst)
        (tick && !shift_pend && !wr_en) |=> shadow_sync); // R10

endmodule

// File: tb/test_rtc_shift_timebase.sv
module test_rtc_shift_timebase;

    localparam int SEC_W = 17;
    localparam int SEC_MOD = 1 << SEC_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             tick = 1'b0;
    logic [14:0]      prediv_s = 15'd9;
    logic [14:0]      ss_cnt;
    logic [SEC_W-1:0] sec_cnt;
    logic [14:0]      shadow_ss;
    logic [SEC_W-1:0] shadow_sec;
    logic             shift_pend;
    logic             shadow_sync;

    always #10 clk = ~clk;

    rtc_shift_timebase #(.SEC_W(SEC_W)) i_rtc_shift_timebase (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
        .prediv_s(prediv_s), .ss_cnt(ss_cnt), .sec_cnt(sec_cnt),
        .shadow_ss(shadow_ss), .shadow_sec(shadow_sec),
        .shift_pend(shift_pend), .shadow_sync(shadow_sync)
    );

    // behavioural reference model
    int m_ss, m_sec, m_sh_ss, m_sh_sec, m_pend, m_sync, m_frac, m_add1;
    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 0;
    logic [31:0] rng = 32'h1234_5679;

    always @(posedge clk) begin
        int pd, ss2, carry, f, sum, wr_ok, app;
        pd = int'(prediv_s);
        if (rst) begin
            m_ss = pd; m_sec = 0; m_sh_ss = 0; m_sh_sec = 0;
            m_pend = 0; m_sync = 0; m_frac = 0; m_add1 = 0;
        end else begin
            wr_ok = (wr_en && m_pend == 0) ? 1 : 0;
            app   = (tick && m_pend == 1) ? 1 : 0;
            if (tick) begin
                if (app == 0) begin
                    m_sh_ss = m_ss; m_sh_sec = m_sec; m_sync = 1;
                end
                if (m_ss == 0) begin ss2 = pd; carry = 1; end
                else begin ss2 = m_ss - 1; carry = 0; end
                m_sec = m_sec + carry;
                if (app == 1) begin
                    f = (m_frac > pd) ? pd : m_frac;
                    sum = ss2 + f;
                    if (sum > pd) begin
                        ss2 = sum - (pd + 1);
                        m_sec = m_sec - 1;
                    end else ss2 = sum;
                    m_sec = m_sec + m_add1;
                    m_pend = 0;
                end
                m_ss = ss2;
                m_sec = (m_sec + SEC_MOD) % SEC_MOD;
            end
            if (wr_ok == 1) begin
                m_pend = 1; m_sync = 0;
                m_frac = int'(wr_data[14:0]);
                m_add1 = int'(wr_data[31]);
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        checks++;
        chk("ss_cnt", int'(ss_cnt), m_ss);
        chk("sec_cnt", int'(sec_cnt), m_sec);
        chk("shadow_ss", int'(shadow_ss), m_sh_ss);
        chk("shadow_sec", int'(shadow_sec), m_sh_sec);
        chk("shift_pend", int'(shift_pend), m_pend);
        chk("shadow_sync", int'(shadow_sync), m_sync);
    endtask

    // drive one cycle at the falling edge, compare at the next falling edge
    task automatic step(input bit w, input logic [31:0] d, input bit t);
        wr_en = w; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        compare_all();
    endtask

    task automatic do_reset(input logic [14:0] pd);
        rst = 1'b1; prediv_s = pd; wr_en = 1'b0; tick = 1'b0;
        @(negedge clk); @(negedge clk);
        cur_req = "R1";
        checks++;
        chk("reset ss", int'(ss_cnt), int'(pd));
        chk("reset sec", int'(sec_cnt), 0);
        chk("reset pend", int'(shift_pend), 0);
        chk("reset sync", int'(shadow_sync), 0);
        chk("reset shadow_sec", int'(shadow_sec), 0);
        rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 1);
    endtask

    task automatic next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(15'd9);

        cur_req = "R2"; // countdown, reload and carry, hold without tick
        ticks(23);
        step(0, '0, 0); step(0, '0, 0);
        ticks(4);

        cur_req = "R3"; // fraction 3, junk in bits 30:15 ignored
        step(1, 32'h7FFF_8003, 0);
        step(0, '0, 0);
        cur_req = "R4"; // ignored write while pending
        step(1, 32'h8000_0007, 0);
        step(0, '0, 0);
        cur_req = "R5";
        step(0, '0, 1);
        cur_req = "R9";
        ticks(3);

        cur_req = "R6"; // steer ss to 2, then add 9: 1+9=10 > 9 wraps to 0
        while (m_ss != 2) step(0, '0, 1);
        step(1, 32'h0000_0009, 0);
        step(0, '0, 1);
        ticks(2);
        cur_req = "R6"; // apply on reload tick: sum exactly at divider
        while (m_ss != 0) step(0, '0, 1);
        step(1, 32'h0000_0000, 0);
        step(0, '0, 1);
        ticks(2);

        cur_req = "R7"; // advance with add-one-second
        step(1, 32'h8000_0004, 0);
        step(0, '0, 1);
        ticks(2);
        step(1, 32'h8000_0000, 0);
        step(0, '0, 1);
        ticks(2);

        cur_req = "R8"; // oversized fraction clamps to divider
        step(1, 32'h0000_7FFF, 0);
        step(0, '0, 1);
        ticks(2);
        step(1, 32'h8000_0020, 0);
        step(0, '0, 1);
        ticks(2);

        cur_req = "R10"; // write in same cycle as a tick
        step(1, 32'h0000_0005, 1);
        step(0, '0, 0);
        step(0, '0, 1);
        ticks(3);

        cur_req = "R8"; // divider of zero
        do_reset(15'd0);
        cur_req = "R8";
        ticks(3);
        step(1, 32'h8000_0003, 0);
        step(0, '0, 1);
        ticks(3);

        cur_req = "R6"; // mixed traffic, divider 2 then 37
        do_reset(15'd2);
        cur_req = "R6";
        for (int i = 0; i < 1500; i++) begin
            next_rng();
            step(rng[3:0] == 4'd0, {rng[31], rng[30:20], 5'd0, 11'd0, rng[18:15]}, rng[6]);
        end
        do_reset(15'd37);
        cur_req = "R7";
        for (int i = 0; i < 1500; i++) begin
            next_rng();
            step(rng[4:0] == 5'd0, {rng[31], 16'd0, 9'd0, rng[21:16]}, rng[7] | rng[8]);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule